// File: doc/BRIEF.md
# Parameterized MSB-First Parallel Serializer

This block turns a parallel word of J bits (J from 3 to 10) into a serial bitstream that advances one bit per cycle of a fast bit clock. Its datapath has two register stages. A capture bank takes the parallel word once per word period, on the single cycle in which a word strobe is high. On the next cycle the word moves into a separate shift register. That register moves its contents toward the high end and puts a zero in at the bottom, and its top bit drives the serial line. Each word therefore leaves highest bit first. Consecutive words follow one another with no gap.

The word strobe comes from one of two places, chosen by a parameter. It can come from an internal modulo-J counter that runs on the fast clock, or from an input pin driven by an outside divider. In both cases the strobe actually used appears on an output, so the core can time its word updates. The core must hold the parallel word steady for the whole word period around the strobe cycle.

Top module: `par_serializer`

## Requirements
- R1: With the internal source selected, `word_strobe` is high for exactly one cycle in every J cycles. After reset is released it first goes high on the cycle after J-1 rising edges.
- R2: The capture bank takes `par_in` only on a rising edge where `word_strobe` is high. Changes to `par_in` at any other time do not reach `ser_out`.
- R3: A word captured on strobe edge E is moved into the shift register at edge E+1. Its first serial bit appears on `ser_out` right after edge E+1.
- R4: Each word leaves MSB first, with bit J-1 first and bit 0 last, at one bit per fast clock cycle.
- R5: With the internal strobe, consecutive words stream back-to-back. Bit 0 of one word is followed in the next cycle by bit J-1 of the next word, with no idle or repeated bit.
- R6: Each shift puts a zero into the LSB. When no new word is transferred, `ser_out` is 0 once the last bit of the previous word has gone out.
- R7: The synchronous active-high reset clears the capture bank, the shift register and the strobe counter. While `rst` is high, `ser_out` and the internal `word_strobe` stay 0. After release, the strobe count starts again from zero.
- R8: With the external source selected, `word_strobe` follows `load_en_in`. With the internal source selected, `load_en_in` has no effect on `ser_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en_in | input | 1 | External word strobe, used only when the external source is selected |
| par_in | input | J | Parallel word from the core |
| ser_out | output | 1 | Serial bitstream, MSB of each word first |
| word_strobe | output | 1 | The strobe in use; the word is captured on edges where it is high |

## Verification
The hardest case to reach is proving that the capture bank ignores the parallel input outside the strobe cycle. Under a normal stream the core holds its word steady, so a bank that samples too often gives the same output. The bench drives the external-strobe instance with one strobe pulse and inverts `par_in` on the very next cycle, before the transfer into the shift register. The original word must still come out bit for bit, followed by zeros while `par_in` keeps changing with no strobe. Streams at J = 3, 8 and 10 toggle the unused strobe input on every cycle, to show that it has no effect in internal mode.

// File: rtl/ser_pkg.sv
package ser_pkg;

    localparam int FACTOR_MIN = 3;
    localparam int FACTOR_MAX = 10;

    typedef enum logic {
        STB_INTERNAL = 1'b0,
        STB_EXTERNAL = 1'b1
    } stb_src_e;

    function automatic int count_width(input int factor);
        return (factor <= 2) ? 1 : $clog2(factor);
    endfunction

endpackage

// File: rtl/ser_strobe_gen.sv
module ser_strobe_gen #(
    parameter int                 J   = 8,
    parameter ser_pkg::stb_src_e  SRC = ser_pkg::STB_INTERNAL
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_le,
    output logic strobe
);
    localparam int CW = ser_pkg::count_width(J);
    localparam logic [CW-1:0] TERM = CW'(J - 1);

    generate
        if (SRC == ser_pkg::STB_INTERNAL) begin : g_int
            logic [CW-1:0] cnt_q;
            logic          unused_ext;
            assign unused_ext = ext_le;

            always_ff @(posedge clk) begin
                if (rst)                cnt_q <= '0;
                else if (cnt_q == TERM) cnt_q <= '0;
                else                    cnt_q <= cnt_q + 1'b1;
            end

            assign strobe = (cnt_q == TERM);

            AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
                cnt_q <= TERM);                                   // R1
            AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
                strobe |=> !strobe);                              // R1
        end else begin : g_ext
            assign strobe = ext_le;
        end
    endgenerate

endmodule

// File: rtl/ser_load_bank.sv
module ser_load_bank #(
    parameter int J = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture,
    input  logic [J-1:0] din,
    output logic [J-1:0] word_q
);
    always_ff @(posedge clk) begin
        if (rst)          word_q <= '0;
        else if (capture) word_q <= din;
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(word_q));                            // R2

endmodule

// File: rtl/ser_shift_out.sv
module ser_shift_out #(
    parameter int J = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         captured,
    input  logic [J-1:0] word,
    output logic [J-1:0] shreg_q,
    output logic         sbit
);
    logic xfer_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            xfer_q  <= 1'b0;
            shreg_q <= '0;
        end else begin
            xfer_q <= captured;
            if (xfer_q) shreg_q <= word;
            else        shreg_q <= {shreg_q[J-2:0], 1'b0};
        end
    end

    assign sbit = shreg_q[J-1];

    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
        !xfer_q |=> $countones(shreg_q) <= $countones($past(shreg_q))); // R6

endmodule

// File: rtl/par_serializer.sv
module par_serializer #(
    parameter int                J   = 8,
    parameter ser_pkg::stb_src_e SRC = ser_pkg::STB_INTERNAL
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en_in,
    input  logic [J-1:0] par_in,
    output logic         ser_out,
    output logic         word_strobe
);
    logic [J-1:0] held_word;
    logic [J-1:0] shift_word;
    logic         strobe;

    ser_strobe_gen #(.J(J), .SRC(SRC)) u_stb (
        .clk    (clk),
        .rst    (rst),
        .ext_le (load_en_in),
        .strobe (strobe)
    );

    ser_load_bank #(.J(J)) u_load (
        .clk     (clk),
        .rst     (rst),
        .capture (strobe),
        .din     (par_in),
        .word_q  (held_word)
    );

    ser_shift_out #(.J(J)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .captured (strobe),
        .word     (held_word),
        .shreg_q  (shift_word),
        .sbit     (ser_out)
    );

    assign word_strobe = strobe;

    AST_WORD_XFER: assert property (@(posedge clk) disable iff (rst)
        strobe |=> ##1 (shift_word == $past(par_in, 2)));         // R3
    AST_FIRST_BIT: assert property (@(posedge clk) disable iff (rst)
        strobe |=> ##1 (ser_out == $past(par_in[J-1], 2)));       // R4

endmodule

// File: tb/sim_par_serializer.sv
module sim_par_serializer;
    localparam int PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic le_x = 1'b0;
    logic le3 = 1'b0;
    logic [7:0] d0 = '0;
    logic [2:0] d1 = '0;
    logic [9:0] d2 = '0;
    logic [4:0] d3 = '0;
    logic s0, s1, s2, s3, w0, w1, w2, w3;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    par_serializer #(.J(8))  u0 (.clk(clk), .rst(rst), .load_en_in(le_x), .par_in(d0), .ser_out(s0), .word_strobe(w0));
    par_serializer #(.J(3))  u1 (.clk(clk), .rst(rst), .load_en_in(le_x), .par_in(d1), .ser_out(s1), .word_strobe(w1));
    par_serializer #(.J(10)) u2 (.clk(clk), .rst(rst), .load_en_in(le_x), .par_in(d2), .ser_out(s2), .word_strobe(w2));
    par_serializer #(.J(5), .SRC(ser_pkg::STB_EXTERNAL)) u3 (.clk(clk), .rst(rst), .load_en_in(le3), .par_in(d3), .ser_out(s3), .word_strobe(w3));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_din(input int j, input logic [9:0] v);
        case (j)
            8:       d0 = v[7:0];
            3:       d1 = v[2:0];
            10:      d2 = v;
            default: d3 = v[4:0];
        endcase
    endtask

    function automatic logic get_sout(input int j);
        case (j)
            8:       return s0;
            3:       return s1;
            10:      return s2;
            default: return s3;
        endcase
    endfunction

    function automatic logic get_stb(input int j);
        case (j)
            8:       return w0;
            3:       return w1;
            10:      return w2;
            default: return w3;
        endcase
    endfunction

    function automatic logic [9:0] pat(input int i, input int seed);
        case (i)
            0:       return 10'h2AA;
            1:       return 10'h155;
            2:       return 10'h3FF;
            3:       return 10'h000;
            default: return 10'((i * 173 + seed) & 10'h3FF);
        endcase
    endfunction

    task automatic test_reset_state;
        repeat (3) begin
            @(negedge clk);
            chk({s0, s1, s2, s3} == 4'b0, "R7 reset sout", {s0, s1, s2, s3}, 0);
            chk({w0, w1, w2} == 3'b0, "R7 reset strobe", {w0, w1, w2}, 0);
        end
    endtask

    // Called at a negedge where rst has just been lowered (t = 0).
    task automatic test_first_strobe(input int j, input string req);
        int t = 0;
        while (get_stb(j) !== 1'b1 && t < 20) begin
            @(negedge clk);
            t++;
        end
        chk(t == j - 1, req, t, j - 1);
    endtask

    task automatic run_stream(input int j, input int nw, input int seed);
        logic [9:0] w [0:7];
        int guard = 0;
        for (int i = 0; i < nw; i++) w[i] = pat(i, seed);
        set_din(j, w[0]);
        @(negedge clk);
        le_x = ~le_x;
        while (get_stb(j) !== 1'b1 && guard < 20) begin
            @(negedge clk);
            le_x = ~le_x;
            guard++;
        end
        for (int t = 1; t <= nw * j + 1; t++) begin
            @(negedge clk);
            le_x = ~le_x;   // R8: ignored in internal mode
            if ((t % j) == 1 && (t / j + 1) < nw) set_din(j, w[t / j + 1]);
            chk(get_stb(j) == ((t % j) == 0), "R1 strobe period", get_stb(j), ((t % j) == 0));
            if (t >= 2) begin
                int idx = (t - 2) / j;
                int bp  = j - 1 - ((t - 2) % j);
                if (idx < nw)
                    chk(get_sout(j) == w[idx][bp], "R4 R5 R8 stream bit", get_sout(j), w[idx][bp]);
            end
        end
    endtask

    task automatic test_external;
        logic [4:0] wd = 5'b10110;
        @(negedge clk);
        d3 = wd;
        le3 = 1'b1;
        #1;
        chk(w3 == 1'b1, "R8 external strobe follows pin", w3, 1);
        @(negedge clk);
        le3 = 1'b0;
        d3 = ~wd;       // R2: changed before transfer
        #1;
        chk(w3 == 1'b0, "R8 external strobe low", w3, 0);
        chk(s3 == 1'b0, "R3 no bit before transfer", s3, 0);
        for (int b = 4; b >= 0; b--) begin
            @(negedge clk);
            d3 = 5'(b * 7);
            chk(s3 == wd[b], "R2 R3 R4 captured word bit", s3, wd[b]);
        end
        repeat (6) begin
            @(negedge clk);
            d3 = ~d3;
            chk(s3 == 1'b0, "R6 R2 zero fill without strobe", s3, 0);
        end
    endtask

    task automatic test_mid_reset;
        @(negedge clk);
        d0 = 8'hFF;
        repeat (10) @(negedge clk);
        chk(s0 == 1'b1, "R4 ones word before reset", s0, 1);
        rst = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk({s0, s1, s2, s3} == 4'b0, "R7 mid reset sout", {s0, s1, s2, s3}, 0);
            chk({w0, w1, w2} == 3'b0, "R7 mid reset strobe", {w0, w1, w2}, 0);
        end
        rst = 1'b0;
        test_first_strobe(10, "R7 R1 strobe restart J10");
    endtask

    initial begin
        test_reset_state;
        @(negedge clk);
        rst = 1'b0;
        test_first_strobe(3, "R1 first strobe J3");
        run_stream(8, 6, 11);
        run_stream(3, 8, 5);
        run_stream(10, 6, 29);
        test_external;
        test_mid_reset;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule